// File: doc/BRIEF.md
# Epoch Calendar Member Selector

This block turns the 64-bit tick carried by each packet into the identity of the worker that should receive it. Resolution takes two steps. First, a bank of ternary entries is compared against the tick. Each entry holds a value, a care mask and a 32-bit epoch number, and the lowest-numbered matching entry supplies the epoch. Second, the epoch is looked up among a small set of physical calendar banks. The bank that carries that epoch is then read at the slot given by the tick's nine low bits, which yields a 16-bit member ID.

Because a member may fill any number of the 512 slots of a calendar, the share of ticks it receives is weighted. Because every packet with a given tick takes the same path through fixed tables, all fragments of one event land on the same member. Control software retires an old calendar without disturbing traffic: it binds a fresh bank to a new epoch, fills the bank, and then moves ternary entries so that future ticks select the new epoch.

A lookup is presented with a valid strobe. Its result appears exactly one cycle later as either a hit carrying a member ID or a drop. The block accepts one lookup per cycle. A single write port carries three kinds of command: set or delete a ternary entry, set or delete a calendar slot, and bind or unbind a calendar bank to an epoch.

Top module: `epoch_cal_sel`

## Requirements
- R1: After reset no result is valid, and all ternary entries, bank bindings and calendar slots are empty, so any lookup is dropped.
- R2: A ternary entry (wr_kind 0) matches when the tick equals the entry value on every bit whose care bit is 1. A care mask of all zeros matches every tick.
- R3: When several ternary entries match, the one with the lowest index supplies the epoch.
- R4: The slot is tick[8:0]. The bank is the one bound (wr_kind 2) to the selected epoch, and the result member is the value stored in that bank at that slot (wr_kind 1).
- R5: A lookup is dropped when no ternary entry matches, when no bank is bound to the selected epoch, or when the addressed slot is empty.
- R6: Any command with wr_del set removes its entry, slot or binding. Binding a bank, or unbinding it, empties all 512 of its slots.
- R7: Every lookup presented with lk_valid produces exactly one result on the next cycle, and lookups may be presented on consecutive cycles.
- R8: A write affects only lookups presented on later cycles. A lookup presented in the same cycle as a write sees the old contents.
- R9: res_hit and res_drop are never both set, each implies res_valid, and res_member is zero whenever res_hit is low.
- R10: A member stored in k slots of a bank receives exactly k of any 512 consecutive ticks that select that bank.
- R11: The same tick resolves to the same member whenever it is looked up, provided the tables have not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_tick | input | 64 | Tick to resolve |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 ternary entry, 1 calendar slot, 2 bank binding, 3 no effect |
| wr_del | input | 1 | Remove instead of set |
| wr_index | input | 7 | Ternary entry index (also its priority) |
| wr_value | input | 64 | Ternary compare value |
| wr_care | input | 64 | Ternary care mask, 1 = compared |
| wr_epoch | input | 32 | Epoch for an entry or for a bank binding |
| wr_bank | input | 2 | Calendar bank for slot or binding commands |
| wr_slot | input | 9 | Calendar slot for slot commands |
| wr_member | input | 16 | Member ID stored in a slot |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Lookup resolved to a member |
| res_drop | output | 1 | Lookup found no member |
| res_member | output | 16 | Selected member ID, zero on drop |

## Verification
The bench targets overlapping ternary entries: if priority were inverted, a narrower low-index range would be hidden behind a wider one and return the wrong member. It issues a write and a lookup in the same cycle: a design that forwarded writes would return the new member one lookup early. It also rebinds a bank and expects its stale slots to be gone, since a design that kept them would serve the old calendar under the new epoch. Finally it sweeps all 512 slots to confirm the weighting, and it checks both the "epoch has no bank" drop and the "single empty slot" drop, which a design with a missing validity test would turn into a hit with a garbage member.

// File: rtl/epoch_cal_sel.sv
module epoch_cal_sel #(
  parameter int TICK_W   = 64,
  parameter int EPOCH_W  = 32,
  parameter int MEMBER_W = 16,
  parameter int ENTRIES  = 128,
  parameter int BANKS    = 4,
  parameter int SLOT_W   = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [TICK_W-1:0]           lk_tick,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_kind,
  input  logic                        wr_del,
  input  logic [$clog2(ENTRIES)-1:0]  wr_index,
  input  logic [TICK_W-1:0]           wr_value,
  input  logic [TICK_W-1:0]           wr_care,
  input  logic [EPOCH_W-1:0]          wr_epoch,
  input  logic [$clog2(BANKS)-1:0]    wr_bank,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [MEMBER_W-1:0]         wr_member,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic                        res_drop,
  output logic [MEMBER_W-1:0]         res_member
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int DEPTH  = BANKS * SLOTS;
  localparam int ADDR_W = BANK_W + SLOT_W;

  logic [TICK_W-1:0]   t_val  [ENTRIES];
  logic [TICK_W-1:0]   t_care [ENTRIES];
  logic [EPOCH_W-1:0]  t_epoch[ENTRIES];
  logic [ENTRIES-1:0]  t_on;
  logic [EPOCH_W-1:0]  bank_tag[BANKS];
  logic [BANKS-1:0]    bank_on;
  logic [MEMBER_W-1:0] cal_mem[DEPTH];
  logic [DEPTH-1:0]    cal_on;

  logic               e_hit, b_hit;
  logic [EPOCH_W-1:0] e_epoch;
  logic [BANK_W-1:0]  b_idx;
  logic [ADDR_W-1:0]  cal_addr;
  logic               hit;

  // ternary stage: scan downward so the lowest matching index is kept last
  always_comb begin
    e_hit   = 1'b0;
    e_epoch = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (t_on[i] && ((lk_tick ^ t_val[i]) & t_care[i]) == '0) begin
        e_hit   = 1'b1;
        e_epoch = t_epoch[i];
      end
    end
  end

  always_comb begin
    b_hit = 1'b0;
    b_idx = '0;
    for (int j = BANKS - 1; j >= 0; j--) begin
      if (bank_on[j] && bank_tag[j] == e_epoch) begin
        b_hit = 1'b1;
        b_idx = BANK_W'(j);
      end
    end
  end

  assign cal_addr = {b_idx, lk_tick[SLOT_W-1:0]};
  assign hit      = e_hit && b_hit && cal_on[cal_addr];

  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == 2'd0 && !wr_del) begin
      t_val[wr_index]   <= wr_value;
      t_care[wr_index]  <= wr_care;
      t_epoch[wr_index] <= wr_epoch;
    end
    if (wr_en && wr_kind == 2'd1 && !wr_del)
      cal_mem[{wr_bank, wr_slot}] <= wr_member;
    if (wr_en && wr_kind == 2'd2 && !wr_del)
      bank_tag[wr_bank] <= wr_epoch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_on    <= '0;
      bank_on <= '0;
      cal_on  <= '0;
    end else if (wr_en) begin
      case (wr_kind)
        2'd0: t_on[wr_index] <= !wr_del;
        2'd1: cal_on[{wr_bank, wr_slot}] <= !wr_del;
        2'd2: begin
          bank_on[wr_bank] <= !wr_del;
          cal_on[{wr_bank, {SLOT_W{1'b0}}} +: SLOTS] <= '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_drop   <= 1'b0;
      res_member <= '0;
    end else begin
      res_valid  <= lk_valid;
      res_hit    <= lk_valid && hit;
      res_drop   <= lk_valid && !hit;
      res_member <= (lk_valid && hit) ? cal_mem[cal_addr] : '0;
    end
  end

  // R9
  hit_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && res_drop));
  // R9
  status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit || res_drop) |-> res_valid);
  // R9
  member_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_member == '0);
  // R7
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (res_valid && (res_hit || res_drop)));
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
endmodule

// File: tb/sim_epoch_cal_sel.sv
module sim_epoch_cal_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [63:0] lk_tick = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic wr_del = 1'b0;
  logic [6:0] wr_index = '0;
  logic [63:0] wr_value = '0, wr_care = '0;
  logic [31:0] wr_epoch = '0;
  logic [1:0] wr_bank = '0;
  logic [8:0] wr_slot = '0;
  logic [15:0] wr_member = '0;
  logic res_valid, res_hit, res_drop;
  logic [15:0] res_member;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  epoch_cal_sel u0 (.*);

  localparam int NV = 10;
  localparam logic [63:0] VT [NV] = '{
    64'h5, 64'hDEAD_BEEF_0000_0180, 64'h1017, 64'h1FFF, 64'h1844,
    64'h1833, 64'h2005, 64'h0FFF, 64'h1900, 64'h18FF };
  localparam logic [16:0] VE [NV] = '{
    {1'b1,16'h000A}, {1'b1,16'h000C}, {1'b1,16'h5017}, {1'b1,16'h51FF},
    {1'b1,16'hA044}, {1'b0,16'h0000}, {1'b0,16'h0000}, {1'b1,16'h000C},
    {1'b1,16'h5100}, {1'b1,16'hA0FF} };

  function automatic logic [15:0] m0(int s);
    return (s < 256) ? 16'h000A : (s < 384) ? 16'h000B : 16'h000C;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_wr(logic [1:0] k, logic d, logic [6:0] idx, logic [63:0] v,
                        logic [63:0] c, logic [31:0] ep, logic [1:0] b,
                        logic [8:0] s, logic [15:0] m);
    wr_en = 1'b1; wr_kind = k; wr_del = d; wr_index = idx; wr_value = v;
    wr_care = c; wr_epoch = ep; wr_bank = b; wr_slot = s; wr_member = m;
  endtask

  task automatic wr(logic [1:0] k, logic d, logic [6:0] idx, logic [63:0] v,
                    logic [63:0] c, logic [31:0] ep, logic [1:0] b,
                    logic [8:0] s, logic [15:0] m);
    @(negedge clk);
    put_wr(k, d, idx, v, c, ep, b, s, m);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns {hit, drop, member} one cycle after presentation
  task automatic look(logic [63:0] t, output logic [17:0] r);
    @(negedge clk);
    lk_valid = 1'b1; lk_tick = t;
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    r = {res_hit, res_drop, res_member};
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] r;
    int cnt[3];
    repeat (3) @(negedge clk);
    check("R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after reset", res_valid, 0);
    look(64'h5, r);
    check("R1 empty tables drop", r, {2'b01, 16'h0});

    // setup
    wr(2, 0, 0, 0, 0, 32'd7, 0, 0, 0);
    wr(2, 0, 0, 0, 0, 32'd9, 1, 0, 0);
    wr(2, 0, 0, 0, 0, 32'h1234_5678, 2, 0, 0);
    wr(0, 0, 127, 0, 0, 32'd7, 0, 0, 0);
    wr(0, 0, 5, 64'h1000, 64'hFFFF_FFFF_FFFF_F000, 32'd9, 0, 0, 0);
    wr(0, 0, 2, 64'h1800, 64'hFFFF_FFFF_FFFF_FF00, 32'h1234_5678, 0, 0, 0);
    wr(0, 0, 10, 64'h2000, 64'hFFFF_FFFF_FFFF_F000, 32'd33, 0, 0, 0);
    for (int s = 0; s < 512; s++) begin
      wr(1, 0, 0, 0, 0, 0, 0, 9'(s), m0(s));
      wr(1, 0, 0, 0, 0, 0, 1, 9'(s), 16'h5000 | 16'(s));
      if (s != 9'h33) wr(1, 0, 0, 0, 0, 0, 2, 9'(s), 16'hA000 | 16'(s));
    end

    // vector table, back-to-back lookups (R2 R3 R4 R5 R7)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R4/R5 vector hit", res_hit, VE[i-1][16]);
        check("R5 vector drop", res_drop, !VE[i-1][16]);
        check("R2/R3/R4 vector member", res_member, VE[i-1][15:0]);
        check("R7 back-to-back valid", res_valid, 1);
      end
      lk_valid = (i < NV); lk_tick = (i < NV) ? VT[i] : '0;
    end
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    check("R7 no result without strobe", res_valid, 0);

    // R11 repeat
    look(64'h1017, r);
    check("R11 same tick same member", r, {2'b10, 16'h5017});

    // R10 weighting sweep over bank0
    cnt = '{0, 0, 0};
    for (int s = 0; s < 512; s++) begin
      look(64'h0000_0077_0000_0000 | 64'(s), r);
      if (r[15:0] == 16'h000A) cnt[0]++;
      else if (r[15:0] == 16'h000B) cnt[1]++;
      else if (r[15:0] == 16'h000C) cnt[2]++;
    end
    check("R10 weight A", cnt[0], 256);
    check("R10 weight B", cnt[1], 128);
    check("R10 weight C", cnt[2], 128);

    // R8 write same cycle as lookup
    @(negedge clk);
    lk_valid = 1'b1; lk_tick = 64'h2005;
    put_wr(2, 0, 0, 0, 0, 32'd33, 3, 0, 0);
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    check("R8 bind not seen same cycle", {res_hit, res_drop}, 2'b01);
    wr(1, 0, 0, 0, 0, 0, 3, 9'h005, 16'h3333);
    look(64'h2005, r);
    check("R8 slot seen after write", r, {2'b10, 16'h3333});
    @(negedge clk);
    lk_valid = 1'b1; lk_tick = 64'h2005;
    put_wr(1, 1, 0, 0, 0, 0, 3, 9'h005, 0);
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    check("R8 delete not seen same cycle", res_member, 16'h3333);
    look(64'h2005, r);
    check("R6 deleted slot drops", r, {2'b01, 16'h0});

    // R6 delete entry 2, then R3 falls to entry 5
    wr(0, 1, 2, 0, 0, 0, 0, 0, 0);
    look(64'h1844, r);
    check("R6/R3 entry delete", r, {2'b10, 16'h5044});
    // R6 rebind empties bank
    wr(2, 0, 0, 0, 0, 32'd9, 1, 0, 0);
    look(64'h1017, r);
    check("R6 rebind empties slots", r, {2'b01, 16'h0});
    // R6 unbind bank0
    wr(2, 1, 0, 0, 0, 0, 0, 0, 0);
    look(64'h5, r);
    check("R6/R5 unbound epoch drops", r, {2'b01, 16'h0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule